// File: doc/BRIEF.md
# Heartbeat Loss Trigger Generator

This block watches a periodic activity signal from a system under test, such as an address strobe or a timer interrupt, and produces a trigger when that activity stops. Once armed, the block waits for the first heartbeat. That heartbeat starts an interval timer, and every later heartbeat restarts it from zero. If the timer reaches the programmed limit before another heartbeat arrives, the block emits a one-cycle trigger pulse for an external instrument. It also raises a sticky stop level that can freeze a capture buffer.

The limit should be set to the longest gap between heartbeats that still counts as healthy. For example, a heartbeat every 8 us with a limit worth 10 us fires 10 us after the last heartbeat. To help choose that value, the block reports the length of the most recent heartbeat gap. The heartbeat input is asynchronous. It passes through a two-flop synchronizer, and either its rising or its falling edge is taken as the event.

Top module: `hbloss_trigger`

## Requirements
- R1: After a synchronous reset, trig_o, stop_o, armed_o and running_o are 0, and gap_o is 0.
- R2: With hb_fall_i = 0, only a 0-to-1 change of hb_i is an event. A level held high produces exactly one event. The event is acted on at the second rising clock edge after the one that first samples the new level.
- R3: A one-cycle arm_i pulse puts the block in the waiting state (armed_o = 1, running_o = 0). In this state no trigger is produced however long no heartbeat arrives.
- R4: The first event after arming starts the timer: running_o becomes 1 at the edge that acts on that event.
- R5: Each later event restarts the timer from zero, so events spaced no more than limit_i+1 cycles apart never trigger.
- R6: Let E be the edge that acts on the last event. If no event follows, trig_o is 1 for exactly the one cycle after edge E+limit_i+1. stop_o becomes 1 at that same edge.
- R7: An event acted on at exactly edge E+limit_i+1 takes priority over the terminal count. It restarts the timer and no trigger is produced.
- R8: While stopped, events are ignored: stop_o stays 1, running_o stays 0, gap_o keeps its value, and no further trigger occurs until the block is re-armed.
- R9: arm_i has priority in every state. It clears stop_o and returns the block to the waiting state at the next edge.
- R10: gap_o holds the number of clock cycles between the last two consecutive events while running, saturating at all ones. The first event after arming does not change it.
- R11: With hb_fall_i = 1, only a 1-to-0 change of hb_i is an event, with the same latency as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle arm / re-arm request |
| hb_i | input | 1 | Asynchronous heartbeat signal |
| hb_fall_i | input | 1 | Edge select: 0 rising, 1 falling |
| limit_i | input | CW | Maximum healthy gap, in cycles past the first |
| trig_o | output | 1 | One-cycle trigger pulse for external equipment |
| stop_o | output | 1 | Sticky stop-capture level after a trigger |
| armed_o | output | 1 | Armed: waiting for or timing heartbeats |
| running_o | output | 1 | Timer active between heartbeats |
| gap_o | output | CW | Last measured heartbeat gap in cycles |

## Verification
The assertions assume that arm_i is the only way out of the stopped state. They also assume that hb_fall_i changes only while hb_i is low, or together with an arm pulse, so that switching the edge select cannot create an event. The stimulus changes the edge select only in the same cycle as an arm pulse, with the heartbeat low. It keeps limit_i fixed during each timing measurement, except in one deliberate step that lowers the limit below the running count. The reference model is checked against gap spacings of exactly limit+1 and limit+2 cycles and against long high heartbeat levels.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIRED = 2'd3
  } hbl_state_e;
endpackage

// File: rtl/hbl_edge_sync.sv
module hbl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  input  logic fall_i,
  output logic event_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // Event qualification: chosen transition of the synchronized level
  always_comb begin
    if (fall_i) event_o = !sync_q[STAGES-1] && prev_q;
    else        event_o = sync_q[STAGES-1] && !prev_q;
  end
endmodule

// File: rtl/hbl_gap_timer.sv
module hbl_gap_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_limit_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear_i)                 cnt_o <= '0;
    else if (run_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end

  assign at_limit_o = (cnt_o >= limit_i);
endmodule

// File: rtl/hbloss_trigger.sv
module hbloss_trigger
  import hbl_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          hb_i,
  input  logic          hb_fall_i,
  input  logic [CW-1:0] limit_i,
  output logic          trig_o,
  output logic          stop_o,
  output logic          armed_o,
  output logic          running_o,
  output logic [CW-1:0] gap_o
);
  localparam logic [CW-1:0] GAP_MAX = {CW{1'b1}};

  hbl_state_e    state_q, state_d;
  logic          hb_ev;
  logic          tmr_clear, tmr_run, tmr_at_limit;
  logic [CW-1:0] tmr_cnt;
  logic          fire;

  hbl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (hb_i),
    .fall_i  (hb_fall_i),
    .event_o (hb_ev)
  );

  hbl_gap_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (tmr_clear),
    .run_i      (tmr_run),
    .limit_i    (limit_i),
    .cnt_o      (tmr_cnt),
    .at_limit_o (tmr_at_limit)
  );

  // Heartbeat beats terminal count; arm beats everything
  assign fire      = !arm_i && state_q == ST_RUN && !hb_ev && tmr_at_limit;
  assign tmr_clear = arm_i || (hb_ev && (state_q == ST_WAIT || state_q == ST_RUN));
  assign tmr_run   = state_q == ST_RUN && !hb_ev && !tmr_at_limit;

  always_comb begin
    state_d = state_q;
    if (arm_i) state_d = ST_WAIT;
    else begin
      case (state_q)
        ST_WAIT:  if (hb_ev) state_d = ST_RUN;
        ST_RUN:   if (fire)  state_d = ST_FIRED;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      trig_o    <= 1'b0;
      stop_o    <= 1'b0;
      armed_o   <= 1'b0;
      running_o <= 1'b0;
      gap_o     <= '0;
    end else begin
      state_q   <= state_d;
      trig_o    <= fire;
      stop_o    <= state_d == ST_FIRED;
      armed_o   <= state_d == ST_WAIT || state_d == ST_RUN;
      running_o <= state_d == ST_RUN;
      if (!arm_i && state_q == ST_RUN && hb_ev)
        gap_o <= (tmr_cnt == GAP_MAX) ? GAP_MAX : tmr_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbloss_trigger_chk.sv
module hbloss_trigger_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          arm_i,
  input logic          trig_o,
  input logic          stop_o,
  input logic          armed_o,
  input logic          running_o,
  input logic [CW-1:0] gap_o
);
  AST_TRIG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o); // R6
  AST_TRIG_WITH_STOP: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> stop_o); // R6
  AST_NO_TRIG_UNLESS_RUNNING: assert property (@(posedge clk) disable iff (rst)
    !running_o |=> !trig_o); // R3
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stop_o && !arm_i) |=> stop_o); // R8
  AST_GAP_FROZEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (stop_o && !arm_i) |=> $stable(gap_o)); // R8
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (!stop_o && armed_o && !running_o && !trig_o)); // R9
  AST_STOP_NOT_ARMED: assert property (@(posedge clk) disable iff (rst)
    !(stop_o && armed_o)); // R9
endmodule

bind hbloss_trigger hbloss_trigger_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .arm_i     (arm_i),
  .trig_o    (trig_o),
  .stop_o    (stop_o),
  .armed_o   (armed_o),
  .running_o (running_o),
  .gap_o     (gap_o)
);

// File: tb/hbloss_trigger_tb.sv
`timescale 1ns/1ps
module hbloss_trigger_tb;
  localparam int CW = 16;
  localparam logic [CW-1:0] GMAX = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arm_i = 1'b0;
  logic          hb_i = 1'b0;
  logic          hb_fall_i = 1'b0;
  logic [CW-1:0] limit_i = 16'd10;
  logic          trig_o, stop_o, armed_o, running_o;
  logic [CW-1:0] gap_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Reference model state
  int m_s1 = 0, m_s2 = 0, m_s3 = 0;
  int m_mode = 0; // 0 idle, 1 waiting, 2 timing, 3 stopped
  int m_cnt = 0;
  int m_gap = 0;
  int m_trig = 0;
  bit started = 1'b0;

  always #2 clk = ~clk;

  hbloss_trigger #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .arm_i(arm_i), .hb_i(hb_i), .hb_fall_i(hb_fall_i),
    .limit_i(limit_i), .trig_o(trig_o), .stop_o(stop_o), .armed_o(armed_o),
    .running_o(running_o), .gap_o(gap_o)
  );

  always @(posedge clk) begin
    bit ev;
    started <= 1'b1;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_mode = 0; m_cnt = 0; m_gap = 0; m_trig = 0;
    end else begin
      ev = hb_fall_i ? (m_s2 == 0 && m_s3 == 1) : (m_s2 == 1 && m_s3 == 0);
      m_trig = 0;
      if (arm_i) begin
        m_mode = 1; m_cnt = 0;
      end else if (m_mode == 1) begin
        if (ev) begin m_mode = 2; m_cnt = 0; end
      end else if (m_mode == 2) begin
        if (ev) begin
          m_gap = (m_cnt + 1 > int'(GMAX)) ? int'(GMAX) : m_cnt + 1;
          m_cnt = 0;
        end else if (m_cnt >= int'(limit_i)) begin
          m_mode = 3; m_trig = 1;
        end else m_cnt = m_cnt + 1;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(hb_i);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (started && !rst) begin
      check(cur_req, "trig_o",    int'(trig_o),    m_trig);
      check(cur_req, "stop_o",    int'(stop_o),    int'(m_mode == 3));
      check(cur_req, "armed_o",   int'(armed_o),   int'(m_mode == 1 || m_mode == 2));
      check(cur_req, "running_o", int'(running_o), int'(m_mode == 2));
      check(cur_req, "gap_o",     int'(gap_o),     m_gap);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d expected <= 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic fall);
    arm_i = 1'b1; hb_fall_i = fall;
    step(1);
    arm_i = 1'b0;
  endtask

  // One-cycle pulse, next pulse starts period cycles later
  task automatic beat(input int period);
    hb_i = 1'b1; step(1);
    hb_i = 1'b0; step(period - 1);
  endtask

  initial begin
    int n;
    step(4);
    rst = 1'b0;
    step(1);
    cur_req = "R1";
    check("R1", "trig_o after reset", int'(trig_o), 0);
    check("R1", "stop_o after reset", int'(stop_o), 0);
    check("R1", "armed_o after reset", int'(armed_o), 0);
    check("R1", "gap_o after reset", int'(gap_o), 0);

    // R3: armed, no heartbeat, never fires
    cur_req = "R3";
    arm(1'b0);
    step(60);
    check("R3", "waiting armed_o", int'(armed_o), 1);
    check("R3", "no trigger without heartbeat", int'(stop_o), 0);

    // R2 / R4: long high level, single start event, latency
    cur_req = "R4";
    hb_i = 1'b1;
    step(2);
    check("R4", "running_o before acted edge", int'(running_o), 0);
    step(1);
    check("R4", "running_o after acted edge", int'(running_o), 1);
    cur_req = "R2";
    step(6);
    hb_i = 1'b0;
    step(2);
    check("R2", "gap_o unchanged by level hold", int'(gap_o), 0);
    check("R10", "first event leaves gap_o", int'(gap_o), 0);

    // R5 / R10: regular heartbeats every 8 cycles
    cur_req = "R5";
    for (int i = 0; i < 6; i++) beat(8);
    check("R5", "no trigger with regular beats", int'(stop_o), 0);
    check("R10", "measured gap", int'(gap_o), 8);

    // R6: trigger timing after last heartbeat
    cur_req = "R6";
    hb_i = 1'b1; n = 0;
    while (n < 200) begin
      step(1); n++;
      if (n == 2) hb_i = 1'b0;
      if (trig_o) break;
    end
    check("R6", "cycles hb to trig", n, int'(limit_i) + 4);
    check("R6", "stop_o at trigger", int'(stop_o), 1);
    step(1);
    check("R6", "trig single cycle", int'(trig_o), 0);

    // R8: ignored heartbeats while stopped
    cur_req = "R8";
    for (int i = 0; i < 4; i++) beat(3);
    step(4);
    check("R8", "stop_o held", int'(stop_o), 1);
    check("R8", "running_o low", int'(running_o), 0);
    check("R8", "gap_o frozen", int'(gap_o), 8);

    // R9: re-arm
    cur_req = "R9";
    arm(1'b0);
    check("R9", "stop_o cleared", int'(stop_o), 0);
    check("R9", "armed_o set", int'(armed_o), 1);

    // R7: gap of exactly limit+1 wins, limit+2 fires
    cur_req = "R7";
    beat(int'(limit_i) + 1);
    beat(int'(limit_i) + 1);
    beat(int'(limit_i) + 1);
    check("R7", "no trigger at terminal count", int'(stop_o), 0);
    check("R10", "gap at terminal count", int'(gap_o), int'(limit_i) + 1);
    beat(int'(limit_i) + 2);
    step(4);
    check("R7", "trigger one cycle later", int'(stop_o), 1);

    // R9: arm while running, then lower limit mid-run
    cur_req = "R9";
    arm(1'b0);
    limit_i = 16'd40;
    beat(20);
    step(10);
    arm(1'b0);
    check("R9", "arm from running", int'(running_o), 0);
    cur_req = "R6";
    beat(30);
    limit_i = 16'd3;
    step(3);
    check("R6", "lowered limit fires", int'(stop_o), 1);

    // R11: falling-edge selection
    cur_req = "R11";
    limit_i = 16'd6;
    arm(1'b1);
    hb_i = 1'b1;
    step(6);
    check("R11", "rising ignored", int'(running_o), 0);
    hb_i = 1'b0;
    step(3);
    check("R11", "falling starts timer", int'(running_o), 1);
    step(12);
    check("R11", "fires after falling edge", int'(stop_o), 1);

    // Limit zero corner
    cur_req = "R6";
    limit_i = 16'd0;
    arm(1'b0);
    beat(1);
    step(6);
    check("R6", "limit zero fires", int'(stop_o), 1);

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule